// File: doc/BRIEF.md
# PCI Base Address and Expansion-ROM Window Decoder

This block holds the address windows of one PCI function: six ordinary base address registers and one expansion-ROM base register. A configuration master writes these registers with dword writes. The block masks each written value to the size of its region and adds the fixed type bits. From the stored values and the I/O and memory enables of the command register, it works out which regions are currently live. For every region it reports the base address, the last address and a valid flag.

The block holds none of the rest of configuration space. Any write it does not claim is signalled on a forward strobe, so that neighbouring configuration storage can take it. The block also has a combinational hit port. It takes an address and an address-space flag, and returns the index of the live region that contains the address. When regions overlap, the lowest index wins.

Region sizes and types are compile-time parameters. A region of size zero is unimplemented. Standard region `i` sits at dword index 4+i of configuration space (byte offset 0x10 + 4*i). The ROM region sits at dword index 12 (byte offset 0x30).

Top module: `cfg_bar_decode`

## Requirements
- R1: A write is claimed only when all four byte enables are set (`cfg_be` = 4'hF), the dword index is 4..9 or 12, and the region at that index has a nonzero size. For every other write, `cfg_wr_fwd` is high in the same cycle and no stored value changes.
- R2: A claimed write to a standard region stores (data AND NOT(size-1)) OR type. The type is bit 0 = 1 for an I/O region, and bit 3 = 1 for a prefetchable memory region.
- R3: A claimed write to the ROM region stores data AND (NOT(size-1) OR 1). Bit 0 is kept as the ROM enable, and no type bits are added.
- R4: A read at `cfg_rd_dw` of an implemented region's dword returns the stored value with `cfg_rd_claim` = 1. Any other index returns zero with `cfg_rd_claim` = 0.
- R5: After reset, each standard register holds only its type bits, the ROM register holds zero, and no region is live.
- R6: An I/O region is live only when the I/O enable is set. A memory region is live only when the memory enable is set.
- R7: The ROM region is live only when the memory enable is set and bit 0 of the ROM register is 1.
- R8: A live region reports base = register AND NOT(size-1) and last = base + size - 1. A region that is not live reports all ones on both.
- R9: An I/O region whose last address is above 0xFFFF is not live. A memory region is not live only if its range would wrap past 2^32; a region that ends exactly at 0xFFFFFFFF is live.
- R10: `hit_valid` is 1 when a live region of the requested space (`hit_space_io` = 1 means I/O) contains `hit_addr`. `hit_region` is then the lowest such index.
- R11: A change of `cmd_io_en` or `cmd_mem_en` affects the live flags from the next clock edge. A claimed register write is visible on the outputs right after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_wr_fwd | output | 1 | Write not claimed, goes to other configuration storage |
| cfg_rd_dw | input | 6 | Dword index of the read |
| cfg_rd_claim | output | 1 | Read index belongs to an implemented region |
| cfg_rd_data | output | 32 | Stored register value |
| cmd_io_en | input | 1 | Command register I/O enable |
| cmd_mem_en | input | 1 | Command register memory enable |
| map_valid | output | 7 | Live flag per region |
| map_base | output | 224 | Base address per region, 32 bits each, region 0 lowest |
| map_last | output | 224 | Last address per region, 32 bits each |
| hit_addr | input | 32 | Address to look up |
| hit_space_io | input | 1 | 1 = I/O lookup, 0 = memory lookup |
| hit_valid | output | 1 | Some live region contains the address |
| hit_region | output | 3 | Index of the winning region |

## Verification
The bench writes all ones for sizing and checks every readback. A design that skipped the size mask, lost the ROM enable bit or added type bits to the ROM would read back the wrong value. It sends partial writes and writes to the unimplemented and out-of-range indices, and expects them forwarded with the stored values unchanged. It moves an I/O window just past 0xFFFF and a memory window up against 0xFFFFFFFF, which catches an off-by-one in either limit. It also sets up overlapping memory windows for the priority check, and times a command-enable change to the exact edge.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

    localparam int NUM_REGIONS      = 7;
    localparam int ROM_INDEX        = 6;
    localparam int REGION_IDX_W     = $clog2(NUM_REGIONS);
    localparam int DWORD_IDX_W      = 6;
    localparam int STD_FIRST_DWORD  = 4;
    localparam int ROM_DWORD        = 12;
    localparam int ADDR_W           = 32;
    localparam logic [ADDR_W-1:0] IO_SPACE_LAST = 32'h0000_FFFF;

    typedef struct packed {
        logic io_en;
        logic mem_en;
    } cmd_state_t;

    function automatic logic [DWORD_IDX_W-1:0] region_dword(input int idx);
        if (idx == ROM_INDEX)
            return DWORD_IDX_W'(ROM_DWORD);
        return DWORD_IDX_W'(STD_FIRST_DWORD + idx);
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_bar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SIZE    = 32'h1000,
    parameter bit                IS_IO   = 1'b0,
    parameter bit                IS_ROM  = 1'b0,
    parameter bit                IS_PREF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              io_en,
    input  logic              mem_en,
    output logic [ADDR_W-1:0] bar_value,
    output logic              mapped,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);

    localparam logic [ADDR_W-1:0] ADDR_MASK = ~(SIZE - 1'b1);
    localparam logic [ADDR_W-1:0] TYPE_BITS = IS_IO   ? 32'h1 :
                                              IS_PREF ? 32'h8 : 32'h0;
    localparam logic [ADDR_W-1:0] KEEP_MASK = IS_ROM ? (ADDR_MASK | 32'h1) : ADDR_MASK;
    localparam logic [ADDR_W-1:0] SET_BITS  = IS_ROM ? 32'h0 : TYPE_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0] bar;
    } slot_state_t;

    slot_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_sel)
            state_d.bar = (wdata & KEEP_MASK) | SET_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '{bar: SET_BITS};
        else
            state_q <= state_d;
    end

    logic [ADDR_W-1:0] base_raw;
    logic [ADDR_W:0]   end_wide;
    logic              space_ok, rom_ok, range_ok;

    always_comb begin
        base_raw = state_q.bar & ADDR_MASK;
        end_wide = {1'b0, base_raw} + {1'b0, SIZE} - 1'b1;
        space_ok = IS_IO ? io_en : mem_en;
        rom_ok   = IS_ROM ? state_q.bar[0] : 1'b1;
        range_ok = IS_IO ? (end_wide <= {1'b0, IO_SPACE_LAST}) : !end_wide[ADDR_W];
        mapped   = space_ok && rom_ok && range_ok;
        base     = mapped ? base_raw : '1;
        last     = mapped ? end_wide[ADDR_W-1:0] : '1;
    end

    assign bar_value = state_q.bar;

endmodule

// File: rtl/cfg_bar_hit.sv
module cfg_bar_hit
    import cfg_bar_pkg::*;
#(
    parameter int                  N_REG   = NUM_REGIONS,
    parameter logic [N_REG-1:0]    IO_MASK = '0
) (
    input  logic [N_REG-1:0]        valid,
    input  logic [N_REG*ADDR_W-1:0] base_flat,
    input  logic [N_REG*ADDR_W-1:0] last_flat,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    space_io,
    output logic                    hit,
    output logic [REGION_IDX_W-1:0] hit_idx
);

    logic [N_REG-1:0] match;

    always_comb begin
        for (int i = 0; i < N_REG; i++) begin
            match[i] = valid[i] && (IO_MASK[i] == space_io) &&
                       (addr >= base_flat[i*ADDR_W +: ADDR_W]) &&
                       (addr <= last_flat[i*ADDR_W +: ADDR_W]);
        end
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_REG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = REGION_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfg_bar_decode.sv
module cfg_bar_decode
    import cfg_bar_pkg::*;
#(
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_SIZES =
        {32'h0001_0000, 32'h0, 32'h0000_0100, 32'h0, 32'h0010_0000, 32'h0000_1000, 32'h0000_0020},
    parameter logic [NUM_REGIONS-1:0] REGION_IO   = 7'b001_0001,
    parameter logic [NUM_REGIONS-1:0] REGION_PREF = 7'b000_0100
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr_en,
    input  logic [DWORD_IDX_W-1:0]          cfg_dw,
    input  logic [3:0]                      cfg_be,
    input  logic [ADDR_W-1:0]               cfg_wdata,
    output logic                            cfg_wr_fwd,
    input  logic [DWORD_IDX_W-1:0]          cfg_rd_dw,
    output logic                            cfg_rd_claim,
    output logic [ADDR_W-1:0]               cfg_rd_data,
    input  logic                            cmd_io_en,
    input  logic                            cmd_mem_en,
    output logic [NUM_REGIONS-1:0]          map_valid,
    output logic [NUM_REGIONS*ADDR_W-1:0]   map_base,
    output logic [NUM_REGIONS*ADDR_W-1:0]   map_last,
    input  logic [ADDR_W-1:0]               hit_addr,
    input  logic                            hit_space_io,
    output logic                            hit_valid,
    output logic [REGION_IDX_W-1:0]         hit_region
);

    localparam int FLAT_W = NUM_REGIONS * ADDR_W;

    cmd_state_t cmd_d, cmd_q;

    always_comb begin
        cmd_d        = cmd_q;
        cmd_d.io_en  = cmd_io_en;
        cmd_d.mem_en = cmd_mem_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else
            cmd_q <= cmd_d;
    end

    logic [NUM_REGIONS-1:0] impl;
    logic [NUM_REGIONS-1:0] wr_sel;
    logic [FLAT_W-1:0]      bar_flat;
    logic                   full_dword;

    assign full_dword = cfg_wr_en && (cfg_be == 4'hF);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam logic [ADDR_W-1:0] SZ = REGION_SIZES[g*ADDR_W +: ADDR_W];
        if (SZ != '0) begin : g_impl
            assign impl[g]   = 1'b1;
            assign wr_sel[g] = full_dword && (cfg_dw == region_dword(g));
            cfg_bar_slot #(
                .SIZE    (SZ),
                .IS_IO   (REGION_IO[g]),
                .IS_ROM  (g == ROM_INDEX),
                .IS_PREF (REGION_PREF[g])
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_sel    (wr_sel[g]),
                .wdata     (cfg_wdata),
                .io_en     (cmd_q.io_en),
                .mem_en    (cmd_q.mem_en),
                .bar_value (bar_flat[g*ADDR_W +: ADDR_W]),
                .mapped    (map_valid[g]),
                .base      (map_base[g*ADDR_W +: ADDR_W]),
                .last      (map_last[g*ADDR_W +: ADDR_W])
            );
        end else begin : g_absent
            assign impl[g]                       = 1'b0;
            assign wr_sel[g]                     = 1'b0;
            assign bar_flat[g*ADDR_W +: ADDR_W]  = '0;
            assign map_valid[g]                  = 1'b0;
            assign map_base[g*ADDR_W +: ADDR_W]  = '1;
            assign map_last[g*ADDR_W +: ADDR_W]  = '1;
        end
    end

    assign cfg_wr_fwd = cfg_wr_en && (wr_sel == '0);

    always_comb begin
        cfg_rd_claim = 1'b0;
        cfg_rd_data  = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (impl[i] && (cfg_rd_dw == region_dword(i))) begin
                cfg_rd_claim = 1'b1;
                cfg_rd_data  = bar_flat[i*ADDR_W +: ADDR_W];
            end
        end
    end

    cfg_bar_hit #(
        .N_REG   (NUM_REGIONS),
        .IO_MASK (REGION_IO)
    ) u_hit (
        .valid     (map_valid),
        .base_flat (map_base),
        .last_flat (map_last),
        .addr      (hit_addr),
        .space_io  (hit_space_io),
        .hit       (hit_valid),
        .hit_idx   (hit_region)
    );

endmodule

// File: rtl/cfg_bar_checker.sv
module cfg_bar_checker
    import cfg_bar_pkg::*;
#(
    parameter logic [NUM_REGIONS-1:0] REGION_IO = '0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr_en,
    input logic [3:0]                    cfg_be,
    input logic                          cfg_wr_fwd,
    input logic                          cmd_io_en,
    input logic                          cmd_mem_en,
    input logic [NUM_REGIONS-1:0]        map_valid,
    input logic [NUM_REGIONS*ADDR_W-1:0] map_base,
    input logic [NUM_REGIONS*ADDR_W-1:0] map_last,
    input logic                          hit_valid,
    input logic [REGION_IDX_W-1:0]       hit_region
);

    a_r1_partial_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_be != 4'hF) |-> cfg_wr_fwd);

    a_r10_hit_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> map_valid[hit_region]);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
        a_r8_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
            !map_valid[g] |-> (map_base[g*ADDR_W +: ADDR_W] == '1 &&
                               map_last[g*ADDR_W +: ADDR_W] == '1));

        a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid[g] |-> (map_last[g*ADDR_W +: ADDR_W] >= map_base[g*ADDR_W +: ADDR_W]));

        if (REGION_IO[g]) begin : g_io
            a_r6_io_enable: assert property (@(posedge clk) disable iff (!rst_n)
                map_valid[g] |-> $past(cmd_io_en));
            a_r9_io_limit: assert property (@(posedge clk) disable iff (!rst_n)
                map_valid[g] |-> (map_last[g*ADDR_W +: ADDR_W] <= IO_SPACE_LAST));
        end else begin : g_mem
            a_r6_mem_enable: assert property (@(posedge clk) disable iff (!rst_n)
                map_valid[g] |-> $past(cmd_mem_en));
        end
    end

    a_r11_mem_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_mem_en) |=> ((map_valid & ~REGION_IO) == '0));

endmodule

bind cfg_bar_decode cfg_bar_checker #(.REGION_IO(REGION_IO)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_be     (cfg_be),
    .cfg_wr_fwd (cfg_wr_fwd),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .map_valid  (map_valid),
    .map_base   (map_base),
    .map_last   (map_last),
    .hit_valid  (hit_valid),
    .hit_region (hit_region)
);

// File: tb/test_cfg_bar_decode.sv
`timescale 1ns/1ps
module test_cfg_bar_decode;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [5:0]   cfg_dw = '0;
    logic [3:0]   cfg_be = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         cfg_wr_fwd;
    logic [5:0]   cfg_rd_dw = '0;
    logic         cfg_rd_claim;
    logic [31:0]  cfg_rd_data;
    logic         cmd_io_en = 1'b0;
    logic         cmd_mem_en = 1'b0;
    logic [6:0]   map_valid;
    logic [223:0] map_base;
    logic [223:0] map_last;
    logic [31:0]  hit_addr = '0;
    logic         hit_space_io = 1'b0;
    logic         hit_valid;
    logic [2:0]   hit_region;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cfg_bar_decode i_cfg_bar_decode (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] base_of(input int i);
        return map_base[i*32 +: 32];
    endfunction

    function automatic logic [31:0] last_of(input int i);
        return map_last[i*32 +: 32];
    endfunction

    // Drive a write at a falling edge; sample the forward strobe before the rising edge.
    task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d,
                      output logic fwd);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        #1 fwd = cfg_wr_fwd;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] dw, output logic claim, output logic [31:0] d);
        cfg_rd_dw = dw;
        #0.5;
        claim = cfg_rd_claim;
        d = cfg_rd_data;
    endtask

    task automatic hit(input logic [31:0] a, input logic io, input logic ev, input logic [2:0] er,
                       input string req);
        hit_addr = a; hit_space_io = io;
        #0.5;
        chk(req, {31'b0, hit_valid}, {31'b0, ev});
        if (ev) chk(req, {29'b0, hit_region}, {29'b0, er});
    endtask

    typedef struct packed {
        logic [5:0]  dw;
        logic [3:0]  be;
        logic [31:0] data;
        logic        fwd;
        logic        claim;
        logic [31:0] rd;
    } vec_t;

    // Sizes: r0 I/O 32, r1 mem 4K, r2 mem 1M prefetch, r3 none, r4 I/O 256, r5 none, ROM 64K.
    localparam vec_t VECS [11] = '{
        '{6'd4,  4'hF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFE1},  // R2 I/O sizing
        '{6'd5,  4'hF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_F000},  // R2 memory sizing
        '{6'd6,  4'hF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFF0_0008},  // R2 prefetch type
        '{6'd12, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_0001},  // R3 ROM sizing
        '{6'd8,  4'hF, 32'h1234_5678, 1'b0, 1'b1, 32'h1234_5601},  // R2
        '{6'd7,  4'hF, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h0},          // R1 unimplemented
        '{6'd4,  4'h3, 32'hAAAA_AAAA, 1'b1, 1'b1, 32'hFFFF_FFE1},  // R1 partial write
        '{6'd12, 4'hF, 32'h000A_5A5A, 1'b0, 1'b1, 32'h000A_0000},  // R3 enable cleared
        '{6'd5,  4'hF, 32'h0000_ABCD, 1'b0, 1'b1, 32'h0000_A000},  // R2
        '{6'd9,  4'hF, 32'h5555_5555, 1'b1, 1'b0, 32'h0},          // R1 region 5 absent
        '{6'd13, 4'hF, 32'h1111_1111, 1'b1, 1'b0, 32'h0}           // R4 outside window
    };

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic        f, c;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        rd(6'd4, c, d);  chk("R5 r0 reset", d, 32'h1);
        rd(6'd6, c, d);  chk("R5 r2 reset", d, 32'h8);
        rd(6'd12, c, d); chk("R5 rom reset", d, 32'h0);
        chk("R5 none live", {25'b0, map_valid}, 32'h0);
        chk("R8 idle base", base_of(1), 32'hFFFF_FFFF);

        // Vector table
        for (int i = 0; i < 11; i++) begin
            wr(VECS[i].dw, VECS[i].be, VECS[i].data, f);
            chk("R1 forward", {31'b0, f}, {31'b0, VECS[i].fwd});
            rd(VECS[i].dw, c, d);
            chk("R4 claim", {31'b0, c}, {31'b0, VECS[i].claim});
            chk("R2 R3 R4 readback", d, VECS[i].rd);
        end

        // R6 I/O only
        wr(6'd4, 4'hF, 32'h0000_C000, f);
        wr(6'd8, 4'hF, 32'h0000_FF00, f);
        wr(6'd5, 4'hF, 32'h0010_0000, f);
        wr(6'd6, 4'hF, 32'h0010_0000, f);
        wr(6'd12, 4'hF, 32'h0020_0000, f);
        cmd_io_en = 1'b1;
        @(negedge clk);
        chk("R6 io live", {25'b0, map_valid}, 32'h11);
        chk("R8 r0 base", base_of(0), 32'h0000_C000);
        chk("R8 r0 last", last_of(0), 32'h0000_C01F);
        chk("R9 r4 ends at FFFF", last_of(4), 32'h0000_FFFF);

        // R9 I/O past 64K
        wr(6'd8, 4'hF, 32'h0001_0000, f);
        chk("R9 io beyond limit", {31'b0, map_valid[4]}, 32'h0);
        chk("R8 dropped base", base_of(4), 32'hFFFF_FFFF);

        // R6 R7 memory
        cmd_mem_en = 1'b1;
        @(negedge clk);
        chk("R6 mem live", {25'b0, map_valid}, 32'h07);
        chk("R7 rom off", {31'b0, map_valid[6]}, 32'h0);
        chk("R8 r2 last", last_of(2), 32'h001F_FFFF);
        wr(6'd12, 4'hF, 32'h0020_0001, f);
        chk("R7 rom live", {31'b0, map_valid[6]}, 32'h1);
        chk("R8 rom base", base_of(6), 32'h0020_0000);
        chk("R8 rom last", last_of(6), 32'h0020_FFFF);

        // R10 lookup
        hit(32'h0010_0010, 1'b0, 1'b1, 3'd1, "R10 overlap lowest");
        hit(32'h0015_0000, 1'b0, 1'b1, 3'd2, "R10 r2");
        hit(32'h0020_0004, 1'b0, 1'b1, 3'd6, "R10 rom");
        hit(32'h0000_C010, 1'b1, 1'b1, 3'd0, "R10 io");
        hit(32'h0000_C010, 1'b0, 1'b0, 3'd0, "R10 wrong space");
        hit(32'h0030_0000, 1'b0, 1'b0, 3'd0, "R10 miss");

        // R11 command timing
        @(negedge clk);
        cmd_mem_en = 1'b0;
        #1 chk("R11 before edge", {31'b0, map_valid[1]}, 32'h1);
        @(negedge clk);
        chk("R11 after edge", {25'b0, map_valid}, 32'h01);
        cmd_mem_en = 1'b1;
        @(negedge clk);

        // R7 clearing ROM enable with memory on
        wr(6'd12, 4'hF, 32'h0020_0000, f);
        chk("R7 rom enable cleared", {31'b0, map_valid[6]}, 32'h0);
        chk("R7 r1 stays", {31'b0, map_valid[1]}, 32'h1);

        // R9 memory at top of space
        wr(6'd5, 4'hF, 32'hFFFF_F000, f);
        chk("R9 top of space live", {31'b0, map_valid[1]}, 32'h1);
        chk("R9 top last", last_of(1), 32'hFFFF_FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule